// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block divides the system clock into time quanta and arranges them into CAN bit times. A single quantum opens each bit and acts as the synchronisation slot. A first phase of programmable length follows it; this phase is the propagation delay plus phase 1. A second phase closes the bit. The block raises a one-cycle strobe on every quantum, at the sample point and on the last quantum of each bit. It also reports which segment is running. The bit-stream logic around it uses these strobes to sample the bus and to step its frame state.

Timing comes from two configuration words. One packs the low prescaler bits and the three segment lengths. The other holds the upper prescaler bits. Both words store each value as its length minus one. The words can change only while the block is held idle and configuration is enabled. A hard-synchronisation input restarts the bit. A resynchronisation edge input stretches phase 1 or cuts phase 2 by at most the jump width. The surrounding logic is expected to pulse these inputs on a recessive-to-dominant bus edge.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the timing word is 0x2301 and the extension word is 0. That gives prescale 2, phase 1 of 4 quanta, phase 2 of 3 quanta and jump width 1, for an 8-quantum bit. While `init` is high, `seg` reads 0 and all strobes stay low.
- R2: A write to either configuration word takes effect only in a cycle where `init` and `cfg_en` are both high. A write in any other cycle leaves the bit timing unchanged.
- R3: `tq_tick` pulses once every P clocks, where P = {ext_in[3:0], timing_in[5:0]} + 1. The extension supplies the upper four bits of P, so P runs from 1 to 1024.
- R4: A bit lasts 1 + (timing_in[11:8]+1) + (timing_in[14:12]+1) quanta. `bit_end` pulses together with the tick of its last quantum. `seg` reads 0 in the sync quantum, 1 in phase 1 and 2 in phase 2.
- R5: `sample_pulse` pulses together with the tick of the last quantum of phase 1.
- R6: While `init` is high the quantum and segment counters are held cleared. After `init` falls, the first bit ends N*P-1 cycles after the first cycle with `init` low, where N is the bit length in quanta.
- R7: A `hard_sync` pulse restarts the prescaler and returns the block to the sync quantum at the next clock edge. The following sample point comes 9 quanta after that edge and the following bit end 13 quanta after it, for a 1+8+4 bit.
- R8: A resync edge seen in quantum k (counted from 0) of phase 1 lengthens phase 1 by min(k+1, SJW) quanta. SJW = timing_in[7:6]+1.
- R9: A resync edge seen in quantum k of phase 2, with r = phase-2 length - k quanta remaining, shortens phase 2 by min(r, SJW). When the shortened phase would already be over, the bit ends on the current quantum. The next bit has its nominal length again.
- R10: Only the first resync edge in a bit is used, and an edge seen in the sync quantum makes no adjustment. Any later edge in the same bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Holds timing idle; first half of the write gate |
| cfg_en | input | 1 | Configuration change enable; second half of the write gate |
| timing_wr | input | 1 | Write strobe for the timing word |
| timing_in | input | 15 | Prescaler low [5:0], jump width [7:6], phase 1 [11:8], phase 2 [14:12], each minus one |
| ext_wr | input | 1 | Write strobe for the extension word |
| ext_in | input | 4 | Upper four prescaler bits |
| hard_sync | input | 1 | Restart the bit at the sync quantum |
| resync_edge | input | 1 | Bus edge for a bounded phase correction |
| tq_tick | output | 1 | One pulse per time quantum |
| sample_pulse | output | 1 | Sample-point strobe |
| bit_end | output | 1 | Last-quantum-of-bit strobe |
| seg | output | 2 | Current segment: 0 sync, 1 phase 1, 2 phase 2 |

## Verification
The bench uses the default widths: a 6-bit prescaler field, a 4-bit extension, a 4-bit phase-1 field, a 3-bit phase-2 field and a 2-bit jump width. With these widths a prescale of 65 needs the extension bits. Prescales of 2 and 3 check the tick spacing. Prescale 1 turns each quantum into a single clock. That puts every resync position in phase 1, phase 2 and the sync slot within cycle-exact reach, including the corrections that are clamped to the jump width and the phase-2 correction that ends the bit immediately.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
    parameter int          BRP_W      = 6,
    parameter int          EXT_W      = 4,
    parameter int          SJW_W      = 2,
    parameter int          TS1_W      = 4,
    parameter int          TS2_W      = 3,
    parameter int unsigned RST_TIMING = 32'h2301,
    localparam int         TIM_W      = BRP_W + SJW_W + TS1_W + TS2_W,
    localparam int         PRE_W      = BRP_W + EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             cfg_en,
    input  logic             timing_wr,
    input  logic [TIM_W-1:0] timing_in,
    input  logic             ext_wr,
    input  logic [EXT_W-1:0] ext_in,
    output logic [PRE_W-1:0] pre_m1,
    output logic [SJW_W-1:0] sjw_m1,
    output logic [TS1_W-1:0] ts1_m1,
    output logic [TS2_W-1:0] ts2_m1
);

    localparam int SJW_LO = BRP_W;
    localparam int TS1_LO = SJW_LO + SJW_W;
    localparam int TS2_LO = TS1_LO + TS1_W;

    typedef struct packed {
        logic [TIM_W-1:0] tim;
        logic [EXT_W-1:0] ext;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic open_w;

    always_comb begin
        cfg_d  = cfg_q;
        open_w = init && cfg_en;
        if (open_w && timing_wr) cfg_d.tim = timing_in;
        if (open_w && ext_wr)    cfg_d.ext = ext_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tim <= TIM_W'(RST_TIMING);
            cfg_q.ext <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pre_m1 = {cfg_q.ext, cfg_q.tim[BRP_W-1:0]};
    assign sjw_m1 = cfg_q.tim[SJW_LO +: SJW_W];
    assign ts1_m1 = cfg_q.tim[TS1_LO +: TS1_W];
    assign ts2_m1 = cfg_q.tim[TS2_LO +: TS2_W];

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && cfg_en) |=> ($stable(cfg_q.tim) && $stable(cfg_q.ext)))
        else $error("timing words changed outside the write gate"); // R2

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             hard_sync,
    input  logic [PRE_W-1:0] pre_m1,
    output logic             tq_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;
    logic   wrap_w;

    always_comb begin
        wrap_w  = (st_q.cnt == pre_m1);
        tq_tick = !init && !hard_sync && wrap_w;
        st_d    = st_q;
        if (init || hard_sync) st_d.cnt = '0;
        else if (wrap_w)       st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && (pre_m1 != '0)) |=> !tq_tick)
        else $error("quantum ticks closer than the prescale"); // R3

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int SJW_W = 2,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    localparam int MAX_W = (TS1_W > TS2_W) ? ((TS1_W > SJW_W) ? TS1_W : SJW_W)
                                           : ((TS2_W > SJW_W) ? TS2_W : SJW_W),
    localparam int QW    = MAX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             hard_sync,
    input  logic             resync_edge,
    input  logic             tq_tick,
    input  logic [SJW_W-1:0] sjw_m1,
    input  logic [TS1_W-1:0] ts1_m1,
    input  logic [TS2_W-1:0] ts2_m1,
    output seg_e             seg,
    output logic             sample_pulse,
    output logic             bit_end
);

    typedef struct packed {
        seg_e          seg;
        logic [QW-1:0] qcnt;
        logic [QW-1:0] ext;
        logic [QW-1:0] shr;
        logic          done;
    } seq_t;

    localparam seq_t IDLE = '{seg: SEG_SYNC, qcnt: '0, ext: '0, shr: '0, done: 1'b0};

    seq_t          st_d, st_q;
    logic [QW-1:0] seg1_len, seg2_len, sjw_len, qn, rem, ext_now, shr_now;
    logic          res_ok, ph1_last, ph2_last;

    always_comb begin
        seg1_len = QW'(ts1_m1) + QW'(1);
        seg2_len = QW'(ts2_m1) + QW'(1);
        sjw_len  = QW'(sjw_m1) + QW'(1);
        res_ok   = resync_edge && !st_q.done && !init && !hard_sync;
        qn       = st_q.qcnt + QW'(1);
        rem      = seg2_len - st_q.qcnt;
        ext_now  = st_q.ext;
        shr_now  = st_q.shr;
        if (res_ok && st_q.seg == SEG_PH1) ext_now = (qn < sjw_len) ? qn : sjw_len;
        if (res_ok && st_q.seg == SEG_PH2) shr_now = (rem < sjw_len) ? rem : sjw_len;
        ph1_last     = (qn >= seg1_len + ext_now);
        ph2_last     = (qn >= seg2_len - shr_now);
        sample_pulse = tq_tick && (st_q.seg == SEG_PH1) && ph1_last;
        bit_end      = tq_tick && (st_q.seg == SEG_PH2) && ph2_last;

        st_d     = st_q;
        st_d.ext = ext_now;
        st_d.shr = shr_now;
        if (res_ok) st_d.done = 1'b1;
        if (tq_tick) begin
            unique case (st_q.seg)
                SEG_SYNC: begin
                    st_d.seg  = SEG_PH1;
                    st_d.qcnt = '0;
                end
                SEG_PH1: begin
                    if (ph1_last) begin
                        st_d.seg  = SEG_PH2;
                        st_d.qcnt = '0;
                    end else begin
                        st_d.qcnt = qn;
                    end
                end
                SEG_PH2: begin
                    if (ph2_last) st_d = IDLE;
                    else          st_d.qcnt = qn;
                end
                default: st_d = IDLE;
            endcase
        end
        if (init || hard_sync) st_d = IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign seg = st_q.seg;

    AST_END_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (st_q.seg == SEG_SYNC && st_q.qcnt == '0))
        else $error("bit end not followed by sync quantum"); // R4

    AST_SAMPLE_TO_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |=> (st_q.seg == SEG_PH2 && st_q.qcnt == '0))
        else $error("sample point not followed by phase 2"); // R5

    AST_INIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init) |-> (st_q.seg == SEG_SYNC && st_q.qcnt == '0))
        else $error("counters not cleared while idle"); // R6

    AST_HSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_sync && !init) |=> (st_q.seg == SEG_SYNC && st_q.qcnt == '0))
        else $error("hard sync did not restart the bit"); // R7

    AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext <= sjw_len)
        else $error("phase 1 stretched beyond jump width"); // R8

    AST_SHR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.shr <= sjw_len)
        else $error("phase 2 cut beyond jump width"); // R9

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int          BRP_W      = 6,
    parameter int          EXT_W      = 4,
    parameter int          SJW_W      = 2,
    parameter int          TS1_W      = 4,
    parameter int          TS2_W      = 3,
    parameter int unsigned RST_TIMING = 32'h2301,
    localparam int         TIM_W      = BRP_W + SJW_W + TS1_W + TS2_W,
    localparam int         PRE_W      = BRP_W + EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             cfg_en,
    input  logic             timing_wr,
    input  logic [TIM_W-1:0] timing_in,
    input  logic             ext_wr,
    input  logic [EXT_W-1:0] ext_in,
    input  logic             hard_sync,
    input  logic             resync_edge,
    output logic             tq_tick,
    output logic             sample_pulse,
    output logic             bit_end,
    output logic [1:0]       seg
);

    logic [PRE_W-1:0] pre_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [TS1_W-1:0] ts1_m1;
    logic [TS2_W-1:0] ts2_m1;
    seg_e             seg_w;

    can_bt_cfg #(
        .BRP_W(BRP_W), .EXT_W(EXT_W), .SJW_W(SJW_W),
        .TS1_W(TS1_W), .TS2_W(TS2_W), .RST_TIMING(RST_TIMING)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .init(init), .cfg_en(cfg_en),
        .timing_wr(timing_wr), .timing_in(timing_in),
        .ext_wr(ext_wr), .ext_in(ext_in),
        .pre_m1(pre_m1), .sjw_m1(sjw_m1), .ts1_m1(ts1_m1), .ts2_m1(ts2_m1)
    );

    can_bt_presc #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .init(init), .hard_sync(hard_sync),
        .pre_m1(pre_m1), .tq_tick(tq_tick)
    );

    can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .init(init), .hard_sync(hard_sync),
        .resync_edge(resync_edge), .tq_tick(tq_tick),
        .sjw_m1(sjw_m1), .ts1_m1(ts1_m1), .ts2_m1(ts2_m1),
        .seg(seg_w), .sample_pulse(sample_pulse), .bit_end(bit_end)
    );

    assign seg = seg_w;

endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b1;
    logic        cfg_en = 1'b0;
    logic        timing_wr = 1'b0;
    logic [14:0] timing_in = '0;
    logic        ext_wr = 1'b0;
    logic [3:0]  ext_in = '0;
    logic        hard_sync = 1'b0;
    logic        resync_edge = 1'b0;
    logic        tq_tick, sample_pulse, bit_end;
    logic [1:0]  seg;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    localparam logic [14:0] CFG_C = 15'h3740; // P=1, phase1 8, phase2 4, SJW 2

    can_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .init(init), .cfg_en(cfg_en),
        .timing_wr(timing_wr), .timing_in(timing_in),
        .ext_wr(ext_wr), .ext_in(ext_in),
        .hard_sync(hard_sync), .resync_edge(resync_edge),
        .tq_tick(tq_tick), .sample_pulse(sample_pulse),
        .bit_end(bit_end), .seg(seg)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        #3;
    endtask

    function automatic bit evt(input int kind);
        case (kind)
            0:       return tq_tick;
            1:       return sample_pulse;
            default: return bit_end;
        endcase
    endfunction

    task automatic find_evt(input int kind, input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            if (evt(kind)) begin
                at = cyc;
                return;
            end
            adv();
        end
    endtask

    task automatic next_evt(input int kind, input int limit, output int at);
        adv();
        find_evt(kind, limit, at);
    endtask

    task automatic cfg_write(input logic [14:0] w, input logic [3:0] e,
                             input logic gate_init, input logic gate_cce);
        @(negedge clk);
        init = gate_init; cfg_en = gate_cce;
        timing_wr = 1'b1; ext_wr = 1'b1; timing_in = w; ext_in = e;
        @(negedge clk);
        timing_wr = 1'b0; ext_wr = 1'b0; cfg_en = 1'b0;
        #3;
    endtask

    task automatic start(output int e0);
        @(negedge clk);
        init = 1'b0;
        #3;
        e0 = cyc;
    endtask

    task automatic stop();
        @(negedge clk);
        init = 1'b1;
        #3;
    endtask

    task automatic pulse(input int n, output bit end_seen, output int at);
        repeat (n) @(negedge clk);
        resync_edge = 1'b1;
        #3;
        end_seen = bit_end;
        at = cyc;
        @(negedge clk);
        resync_edge = 1'b0;
        #3;
    endtask

    task automatic t_reset();
        repeat (3) adv();
        chk_eq("R1 seg in reset", seg, 0);
        chk_eq("R1 strobes in reset", {tq_tick, sample_pulse, bit_end}, 0);
        @(negedge clk); rst_n = 1'b1; #3;
        adv();
        chk_eq("R1 strobes idle after reset", {tq_tick, sample_pulse, bit_end, seg}, 0);
    endtask

    task automatic t_defaults();
        int e0, b, b2, t0, t1;
        start(e0);
        find_evt(2, 100, b);
        chk_eq("R1 default first bit end", b, e0 + 15);
        next_evt(2, 100, b2);
        chk_eq("R4 default bit period", b2 - b, 16);
        next_evt(0, 10, t0);
        next_evt(0, 10, t1);
        chk_eq("R3 default quantum spacing", t1 - t0, 2);
        stop();
    endtask

    task automatic t_locked();
        int e0, b, b2;
        cfg_write(CFG_C, 4'h0, 1'b1, 1'b0);
        start(e0);
        find_evt(2, 100, b);
        chk_eq("R2 write without cfg_en ignored", b, e0 + 15);
        cfg_write(CFG_C, 4'h0, 1'b0, 1'b1);
        find_evt(2, 100, b);
        next_evt(2, 100, b2);
        chk_eq("R2 write while running ignored", b2 - b, 16);
        stop();
    endtask

    task automatic t_cfg_b();
        int e0, b, s, b2, t0, t1;
        cfg_write(15'h2502, 4'h0, 1'b1, 1'b1);
        start(e0);
        find_evt(2, 200, b);
        chk_eq("R6 first bit end prescale 3", b, e0 + 29);
        next_evt(1, 100, s);
        chk_eq("R5 sample offset prescale 3", s - b, 21);
        find_evt(2, 100, b2);
        chk_eq("R4 bit period 10 quanta x3", b2 - b, 30);
        next_evt(0, 10, t0);
        next_evt(0, 10, t1);
        chk_eq("R3 quantum spacing 3", t1 - t0, 3);
        stop();
    endtask

    task automatic t_ext();
        int e0, b, s, t0, t1;
        cfg_write(15'h0100, 4'h1, 1'b1, 1'b1);
        start(e0);
        find_evt(2, 400, b);
        chk_eq("R3 extension bit end", b, e0 + 259);
        next_evt(1, 400, s);
        chk_eq("R5 sample offset prescale 65", s - b, 195);
        next_evt(0, 100, t0);
        next_evt(0, 100, t1);
        chk_eq("R3 extension quantum spacing", t1 - t0, 65);
        stop();
    endtask

    task automatic t_init_hold();
        int e0, b, viol;
        cfg_write(CFG_C, 4'h0, 1'b1, 1'b1);
        start(e0);
        find_evt(2, 100, b);
        stop();
        viol = 0;
        for (int i = 0; i < 20; i++) begin
            if (tq_tick || sample_pulse || bit_end || seg != 2'd0) viol++;
            adv();
        end
        chk_eq("R6 no activity while init held", viol, 0);
        start(e0);
        find_evt(2, 100, b);
        chk_eq("R6 first bit end after release", b, e0 + 12);
    endtask

    task automatic t_hsync();
        int b, h, s, e;
        next_evt(2, 100, b);
        repeat (5) adv();
        @(negedge clk); hard_sync = 1'b1; #3;
        h = cyc;
        @(negedge clk); hard_sync = 1'b0; #3;
        chk_eq("R7 sync quantum after hard sync", seg, 0);
        find_evt(1, 100, s);
        chk_eq("R7 sample after hard sync", s - h, 9);
        find_evt(2, 100, e);
        chk_eq("R7 bit end after hard sync", e - h, 13);
    endtask

    task automatic ph1_case(input int j, input int exp_s, input int exp_e);
        int b, s, e, at;
        bit seen;
        next_evt(2, 100, b);
        pulse(j, seen, at);
        find_evt(1, 100, s);
        chk_eq($sformatf("R8 sample with resync at +%0d", j), s - b, exp_s);
        find_evt(2, 100, e);
        chk_eq($sformatf("R8 bit end with resync at +%0d", j), e - b, exp_e);
    endtask

    task automatic t_ph2();
        int b, e, at, b2;
        bit seen;
        next_evt(2, 100, b);
        pulse(10, seen, at);
        find_evt(2, 100, e);
        chk_eq("R9 phase 2 cut from first quantum", e - b, 11);
        next_evt(2, 100, b);
        pulse(12, seen, at);
        chk_eq("R9 bit ends on the resync quantum", int'(seen), 1);
        chk_eq("R9 immediate end position", at - b, 12);
        next_evt(2, 100, b2);
        chk_eq("R9 next bit nominal", b2 - at, 13);
    endtask

    task automatic t_ignored();
        int b, s, e, at;
        bit seen;
        next_evt(2, 100, b);
        pulse(1, seen, at);
        find_evt(1, 100, s);
        chk_eq("R10 resync in sync slot sample", s - b, 9);
        find_evt(2, 100, e);
        chk_eq("R10 resync in sync slot bit end", e - b, 13);
        next_evt(2, 100, b);
        pulse(2, seen, at);
        pulse(2, seen, at);
        find_evt(2, 100, e);
        chk_eq("R10 second resync in bit ignored", e - b, 14);
    endtask

    initial begin
        #1_600_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_defaults();
        t_locked();
        t_cfg_b();
        t_ext();
        t_init_hold();
        t_hsync();
        ph1_case(2, 10, 14);
        ph1_case(6, 11, 15);
        ph1_case(9, 11, 15);
        t_ph2();
        t_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule